// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block condenses a handful of architectural control bits into one registered mode summary. The bits are long-mode-active, the protection-enable and paging bits of the first control register, the code-segment long, default-size and privilege fields, the stack-segment default-size bit and the virtual-8086 flag. The summary gives a two-level mode (legacy or long), a submode, the current privilege level, the paging state, and the default and alternate operand and address sizes together with the stack size. Instruction-decode logic reads the summary every cycle, so it never has to look at the raw registers.

The summary is a cache. It is refreshed only on a clock edge where the surrounding register file signals a write to one of the source registers (one strobe per register), or where a refresh strobe is high. A refresh carries no data. It only makes the register recompute from the values currently on the source inputs. At all other times the summary holds, even if the source inputs move. No data stream crosses this block, so every pin is a plain control or status signal with no handshake.

Top module: `mode_summary_unit`

## Requirements
- R1: `mode_long` is 1 exactly when `efer_lma` was 1 at the updating edge; otherwise the mode is legacy (0).
- R2: `submode` codes: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit. In long mode `cs_long`=1 gives 4, else 3. In legacy mode `flags_vm`=1 gives 2 (ahead of `cr0_pe`), else `cr0_pe`=1 gives 1, else 0.
- R3: `cpl` equals the `cs_dpl` value sampled at the updating edge.
- R4: `paging` equals the `cr0_pg` value sampled at the updating edge.
- R5: Sizes are byte counts (2, 4, 8). In submode 4 or with `cs_dflt`=1, the operand size is 4 and the alternate is 2. Otherwise the operand size is 2 and the alternate is 4.
- R6: The address size is 8 with alternate 4 in submode 4. Otherwise it is 4 with alternate 2 when `cs_dflt`=1, and 2 with alternate 4 when `cs_dflt`=0.
- R7: The stack size is 8 in submode 4. Otherwise it is 4 when `ss_dflt`=1 and 2 when `ss_dflt`=0.
- R8: The summary takes new values only on an edge where any `src_wr` bit or `refresh` is 1. That edge is the first edge of the strobe cycle. With no strobe, changes on the source inputs have no effect on any output.
- R9: A `refresh` pulse alone recomputes the whole summary from the current source inputs.
- R10: While `rst_n` is 0 the summary holds legacy mode and real submode, with `cpl` 0 and paging off. The sizes are operand 2/alternate 4, address 2/alternate 4 and stack 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| efer_lma | input | 1 | Long-mode-active bit of the extended-feature register |
| cr0_pe | input | 1 | Protection enable |
| cr0_pg | input | 1 | Paging enable |
| cs_long | input | 1 | Code-segment 64-bit attribute |
| cs_dflt | input | 1 | Code-segment default-size attribute |
| cs_dpl | input | 2 | Code-segment descriptor privilege |
| ss_dflt | input | 1 | Stack-segment default-size attribute |
| flags_vm | input | 1 | Virtual-8086 flag |
| src_wr | input | 5 | One write strobe per source register |
| refresh | input | 1 | Recompute request, no data |
| mode_long | output | 1 | 1 long, 0 legacy |
| submode | output | 3 | Submode code (R2) |
| cpl | output | 2 | Current privilege level |
| paging | output | 1 | Paging active |
| op_size | output | 4 | Default operand size, bytes |
| op_alt | output | 4 | Alternate operand size, bytes |
| addr_size | output | 4 | Default address size, bytes |
| addr_alt | output | 4 | Alternate address size, bytes |
| stack_size | output | 4 | Stack size, bytes |

## Verification
Every output field is due one edge after a strobe. The strobe and the source values are driven together on a falling edge, and the rising edge that follows loads the summary. The bench reads the fields on the next falling edge, after one register stage and before any further stimulus. For the hold case of R8, the inputs change while no strobe is driven, and the outputs are read on two later falling edges. A refresh then follows, and its result is read one edge after that.

// File: rtl/mode_summary_pkg.sv
package mode_summary_pkg;
  localparam int SZ_W    = 4;
  localparam int PRIV_W  = 2;
  localparam int NUM_SRC = 5;

  localparam logic [SZ_W-1:0] BYTES2 = SZ_W'(2);
  localparam logic [SZ_W-1:0] BYTES4 = SZ_W'(4);
  localparam logic [SZ_W-1:0] BYTES8 = SZ_W'(8);

  typedef enum logic [2:0] {
    SM_REAL   = 3'd0,
    SM_PROT   = 3'd1,
    SM_V86    = 3'd2,
    SM_COMPAT = 3'd3,
    SM_LONG64 = 3'd4
  } submode_e;

  typedef struct packed {
    logic              mode_long;
    submode_e          sub;
    logic [PRIV_W-1:0] cpl;
    logic              paging;
    logic [SZ_W-1:0]   op;
    logic [SZ_W-1:0]   op_alt;
    logic [SZ_W-1:0]   ad;
    logic [SZ_W-1:0]   ad_alt;
    logic [SZ_W-1:0]   stk;
  } summary_t;
endpackage

// File: rtl/mode_classify.sv
module mode_classify
  import mode_summary_pkg::*;
(
  input  logic     lma,
  input  logic     pe,
  input  logic     vm,
  input  logic     cs_long,
  output logic     is_long,
  output submode_e sub
);
  always_comb begin
    is_long = lma;
    if (lma) begin
      sub = cs_long ? SM_LONG64 : SM_COMPAT;
    end else if (vm) begin
      sub = SM_V86;
    end else if (pe) begin
      sub = SM_PROT;
    end else begin
      sub = SM_REAL;
    end
  end
endmodule

// File: rtl/size_derive.sv
module size_derive
  import mode_summary_pkg::*;
(
  input  submode_e        sub,
  input  logic            cs_dflt,
  input  logic            ss_dflt,
  output logic [SZ_W-1:0] op,
  output logic [SZ_W-1:0] op_alt,
  output logic [SZ_W-1:0] ad,
  output logic [SZ_W-1:0] ad_alt,
  output logic [SZ_W-1:0] stk
);
  logic wide64;
  assign wide64 = (sub == SM_LONG64);

  always_comb begin
    if (wide64 || cs_dflt) begin
      op     = BYTES4;
      op_alt = BYTES2;
    end else begin
      op     = BYTES2;
      op_alt = BYTES4;
    end

    if (wide64) begin
      ad     = BYTES8;
      ad_alt = BYTES4;
    end else if (cs_dflt) begin
      ad     = BYTES4;
      ad_alt = BYTES2;
    end else begin
      ad     = BYTES2;
      ad_alt = BYTES4;
    end

    if (wide64)       stk = BYTES8;
    else if (ss_dflt) stk = BYTES4;
    else              stk = BYTES2;
  end
endmodule

// File: rtl/mode_summary_unit.sv
module mode_summary_unit
  import mode_summary_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               efer_lma,
  input  logic               cr0_pe,
  input  logic               cr0_pg,
  input  logic               cs_long,
  input  logic               cs_dflt,
  input  logic [PRIV_W-1:0]  cs_dpl,
  input  logic               ss_dflt,
  input  logic               flags_vm,
  input  logic [NUM_SRC-1:0] src_wr,
  input  logic               refresh,
  output logic               mode_long,
  output logic [2:0]         submode,
  output logic [PRIV_W-1:0]  cpl,
  output logic               paging,
  output logic [SZ_W-1:0]    op_size,
  output logic [SZ_W-1:0]    op_alt,
  output logic [SZ_W-1:0]    addr_size,
  output logic [SZ_W-1:0]    addr_alt,
  output logic [SZ_W-1:0]    stack_size
);
  localparam summary_t RESET_SUM = '{
    mode_long: 1'b0, sub: SM_REAL, cpl: '0, paging: 1'b0,
    op: BYTES2, op_alt: BYTES4, ad: BYTES2, ad_alt: BYTES4, stk: BYTES2};

  logic     trig;
  logic     nx_long;
  submode_e nx_sub;
  summary_t nx_sum, sum_q;

  assign trig = (|src_wr) | refresh;

  mode_classify u_class (
    .lma     (efer_lma),
    .pe      (cr0_pe),
    .vm      (flags_vm),
    .cs_long (cs_long),
    .is_long (nx_long),
    .sub     (nx_sub)
  );

  size_derive u_size (
    .sub     (nx_sub),
    .cs_dflt (cs_dflt),
    .ss_dflt (ss_dflt),
    .op      (nx_sum.op),
    .op_alt  (nx_sum.op_alt),
    .ad      (nx_sum.ad),
    .ad_alt  (nx_sum.ad_alt),
    .stk     (nx_sum.stk)
  );

  assign nx_sum.mode_long = nx_long;
  assign nx_sum.sub       = nx_sub;
  assign nx_sum.cpl       = cs_dpl;
  assign nx_sum.paging    = cr0_pg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum_q <= RESET_SUM;
    else if (trig) sum_q <= nx_sum;
  end

  assign mode_long  = sum_q.mode_long;
  assign submode    = sum_q.sub;
  assign cpl        = sum_q.cpl;
  assign paging     = sum_q.paging;
  assign op_size    = sum_q.op;
  assign op_alt     = sum_q.op_alt;
  assign addr_size  = sum_q.ad;
  assign addr_alt   = sum_q.ad_alt;
  assign stack_size = sum_q.stk;

  // R8
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(sum_q));

  // R1
  long_submode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_long |-> (submode == 3'd3 || submode == 3'd4));

  // R7
  stack64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (submode == 3'd4) |-> (stack_size == 4'd8 && addr_size == 4'd8));

  // R4
  paging_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (paging == $past(cr0_pg)));

  // R3
  cpl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cpl == $past(cs_dpl)));
endmodule

// File: tb/mode_summary_unit_tb.sv
module mode_summary_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       efer_lma = 0, cr0_pe = 0, cr0_pg = 0, cs_long = 0, cs_dflt = 0;
  logic [1:0] cs_dpl = 0;
  logic       ss_dflt = 0, flags_vm = 0;
  logic [4:0] src_wr = 0;
  logic       refresh = 0;
  logic       mode_long, paging;
  logic [2:0] submode;
  logic [1:0] cpl;
  logic [3:0] op_size, op_alt, addr_size, addr_alt, stack_size;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mode_summary_unit u_dut (.*);

  // input packing: {lma, pe, pg, cs_long, cs_dflt, dpl[1:0], ss_dflt, vm}
  localparam int NV = 10;
  localparam logic [8:0] VIN [NV] = '{
    9'b0_0_0_0_0_00_0_0,
    9'b0_1_1_0_1_00_1_0,
    9'b0_1_1_0_0_11_0_1,
    9'b1_1_1_1_0_11_0_0,
    9'b1_1_1_0_0_10_1_0,
    9'b1_1_1_0_1_01_0_0,
    9'b1_1_1_1_1_00_1_1,
    9'b0_0_0_1_0_00_0_0,
    9'b0_1_0_0_0_01_1_0,
    9'b0_0_0_0_1_00_1_1};
  // expected: {mode, sub[2:0], cpl[1:0], pg, op, op_alt, ad, ad_alt, stk}
  localparam logic [26:0] VEXP [NV] = '{
    {1'b0, 3'd0, 2'd0, 1'b0, 4'd2, 4'd4, 4'd2, 4'd4, 4'd2},
    {1'b0, 3'd1, 2'd0, 1'b1, 4'd4, 4'd2, 4'd4, 4'd2, 4'd4},
    {1'b0, 3'd2, 2'd3, 1'b1, 4'd2, 4'd4, 4'd2, 4'd4, 4'd2},
    {1'b1, 3'd4, 2'd3, 1'b1, 4'd4, 4'd2, 4'd8, 4'd4, 4'd8},
    {1'b1, 3'd3, 2'd2, 1'b1, 4'd2, 4'd4, 4'd2, 4'd4, 4'd4},
    {1'b1, 3'd3, 2'd1, 1'b1, 4'd4, 4'd2, 4'd4, 4'd2, 4'd2},
    {1'b1, 3'd4, 2'd0, 1'b1, 4'd4, 4'd2, 4'd8, 4'd4, 4'd8},
    {1'b0, 3'd0, 2'd0, 1'b0, 4'd2, 4'd4, 4'd2, 4'd4, 4'd2},
    {1'b0, 3'd1, 2'd1, 1'b0, 4'd2, 4'd4, 4'd2, 4'd4, 4'd4},
    {1'b0, 3'd2, 2'd0, 1'b0, 4'd4, 4'd2, 4'd4, 4'd2, 4'd4}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [26:0] e);
    chk({tag, " R1 mode"},   8'(mode_long),  8'(e[26]));
    chk({tag, " R2 sub"},    8'(submode),    8'(e[25:23]));
    chk({tag, " R3 cpl"},    8'(cpl),        8'(e[22:21]));
    chk({tag, " R4 pg"},     8'(paging),     8'(e[20]));
    chk({tag, " R5 op"},     8'({op_size, op_alt}),     {e[19:16], e[15:12]});
    chk({tag, " R6 addr"},   8'({addr_size, addr_alt}), {e[11:8], e[7:4]});
    chk({tag, " R7 stack"},  8'(stack_size), 8'(e[3:0]));
  endtask

  task automatic drive_src(input logic [8:0] v);
    {efer_lma, cr0_pe, cr0_pg, cs_long, cs_dflt, cs_dpl, ss_dflt, flags_vm} = v;
  endtask

  localparam logic [26:0] RST_EXP = {1'b0, 3'd0, 2'd0, 1'b0, 4'd2, 4'd4, 4'd2, 4'd4, 4'd2};

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R10 in-reset", RST_EXP);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R10 after-release", RST_EXP);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive_src(VIN[i]);
      src_wr = 5'(1 << (i % 5));
      @(negedge clk);
      src_wr = '0;
      chk_all($sformatf("vec%0d R8", i), VEXP[i]);
    end

    // R8: inputs change without strobe -> outputs hold (last vector result)
    @(negedge clk);
    drive_src(VIN[3]);
    @(negedge clk);
    @(negedge clk);
    chk_all("R8 hold", VEXP[NV-1]);

    // R9: refresh alone picks up the current inputs
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    chk_all("R9 refresh", VEXP[3]);

    // R8: back-to-back strobes, each edge takes the new value
    drive_src(VIN[4]);
    src_wr = 5'b10000;
    @(negedge clk);
    chk_all("R8 b2b-a", VEXP[4]);
    drive_src(VIN[2]);
    @(negedge clk);
    src_wr = '0;
    chk_all("R8 b2b-b", VEXP[2]);

    // R10: reset mid-run returns to the real-mode defaults
    drive_src(VIN[3]);
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R10 mid-run", RST_EXP);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R10 no-strobe-after", RST_EXP);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule